// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds for a precision time protocol clock. On every clock edge while counting is enabled, it adds a programmable fixed-point step to the count. The step has 32 integer bits and 32 fractional bits. The fractional part collects in a 32-bit accumulator, and each carry out of that accumulator adds one more nanosecond to the count. Because the count covers the full 64 bits of nanoseconds, no separate cycle counter and no overflow handling are needed. The live count is exported on a wide output so that timestamp capture logic can sample it.

Software reaches the block through a simple 32-bit register port with read and write strobes. The time value and the step value are 64 bits wide, so each one spans two words, and updates must be coherent across the two halves. For a write, the low word is held in a staging register, and the whole 64-bit value takes effect only when the high word is written. For a read, reading the low word of the time captures the upper half of the time into a snapshot, and a later read of the high word returns that snapshot. Typical steps are 0x01_9999_9999 (about 1.6 ns), 0x03_3333_3333 (about 3.2 ns) and 0x20_0000_0000 (32 ns). A step of zero stops the clock.

Top module: `tod_counter`

## Requirements
- R1: After reset the time, the running step, the fractional accumulator and the enable are all zero, and register reads return zero.
- R2: While enabled, each clock edge adds the step's integer part (bits 63:32) to the time, plus one when adding the step's fraction (bits 31:0) to the 32-bit fractional accumulator carries out. The time wraps modulo 2^64.
- R3: Bit 0 of the control register at offset 0x10 enables counting. While it is 0, the time holds.
- R4: A running step of zero holds the time, even while counting is enabled.
- R5: A write to offset 0x00 only stages the low time word. A write to offset 0x04 loads {written word, staged word} as the new time, and the new time is visible on `tod_ns` from the edge of that write.
- R6: A time load also clears the fractional accumulator, and it takes priority over that cycle's step.
- R7: A write to offset 0x08 only stages the low step word, and the running step is unchanged. A write to offset 0x0C makes {written word, staged word} the running step.
- R8: A read of offset 0x00 returns the low time word and captures the high time word into a snapshot. A read of offset 0x04 returns the snapshot, not the live value. Read data appear on `bus_rdata` one edge after the read strobe and hold until the next read.
- R9: Reads of offsets 0x08 and 0x0C return the low and high words of the running step. A read of offset 0x10 returns the enable in bit 0 and zeros in all other bits.
- R10: Writes to offsets outside 0x00, 0x04, 0x08, 0x0C and 0x10 change no state, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time may advance on each rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tod_ns | output | 64 | Live nanosecond time |

## Verification
A write that loads the time or commits the step takes effect at the same edge that samples the strobe. The loaded time is therefore on `tod_ns` right after that edge, and the new step is first added at the following edge. Read data are registered, so they are valid after the edge that samples the read strobe. The bench drives strobes 1 ns after an edge and samples 1 ns after the edge that completes each access. For counting checks it opens the enable with one write and closes it with another write exactly N edges later, so that exactly N steps are applied. This makes every expected count a closed-form sum of the integer parts and the fractional carries.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_TIME_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_TIME_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STEP_LO = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STEP_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h10;

    localparam int CTRL_RUN_BIT = 0;

endpackage

// File: rtl/tod_regif.sv
module tod_regif
    import tod_pkg::*;
#(
    parameter int BUS_W = 32,
    localparam int WIDE_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [WIDE_W-1:0] live_time,
    output logic              time_load,
    output logic [WIDE_W-1:0] time_load_val,
    output logic [WIDE_W-1:0] step_q,
    output logic              run_q
);

    typedef struct packed {
        logic [BUS_W-1:0]  time_lo_stage;
        logic [BUS_W-1:0]  step_lo_stage;
        logic [WIDE_W-1:0] step;
        logic              run;
        logic [BUS_W-1:0]  snap_hi;
        logic [BUS_W-1:0]  rdata;
    } regif_t;

    regif_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        time_load     = 1'b0;
        time_load_val = {bus_wdata, st_q.time_lo_stage};
        if (bus_wr) begin
            case (bus_addr)
                OFS_TIME_LO: st_d.time_lo_stage = bus_wdata;
                OFS_TIME_HI: time_load          = 1'b1;
                OFS_STEP_LO: st_d.step_lo_stage = bus_wdata;
                OFS_STEP_HI: st_d.step          = {bus_wdata, st_q.step_lo_stage};
                OFS_CTRL:    st_d.run           = bus_wdata[CTRL_RUN_BIT];
                default:     ;
            endcase
        end
        if (bus_rd) begin
            case (bus_addr)
                OFS_TIME_LO: begin
                    st_d.rdata   = live_time[BUS_W-1:0];
                    st_d.snap_hi = live_time[WIDE_W-1:BUS_W];
                end
                OFS_TIME_HI: st_d.rdata = st_q.snap_hi;
                OFS_STEP_LO: st_d.rdata = st_q.step[BUS_W-1:0];
                OFS_STEP_HI: st_d.rdata = st_q.step[WIDE_W-1:BUS_W];
                OFS_CTRL:    st_d.rdata = {{(BUS_W-1){1'b0}}, st_q.run};
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign step_q    = st_q.step;
    assign run_q     = st_q.run;

    // R7: staging the low step word leaves the running step alone
    a_r7_lo_stage_keeps_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STEP_LO) |=> $stable(step_q));

    // R10: unmapped reads return zero
    a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != OFS_TIME_LO && bus_addr != OFS_TIME_HI &&
         bus_addr != OFS_STEP_LO && bus_addr != OFS_STEP_HI && bus_addr != OFS_CTRL)
        |=> (bus_rdata == '0));

    // R8: a high-word read does not disturb the snapshot it returns
    a_r8_hi_read_stable_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_TIME_HI) |=> $stable(st_q.snap_hi));

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64,
    localparam int INT_W = STEP_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    input  logic              load,
    input  logic [NS_W-1:0]   load_val,
    output logic [NS_W-1:0]   time_q
);

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } acc_t;

    acc_t acc_q, acc_d;
    logic [FRAC_W:0]  frac_sum;
    logic [INT_W-1:0] step_int;

    assign step_int = step[STEP_W-1:FRAC_W];

    always_comb begin
        acc_d    = acc_q;
        frac_sum = {1'b0, acc_q.frac} + {1'b0, step[FRAC_W-1:0]};
        if (load) begin
            acc_d.ns   = load_val;
            acc_d.frac = '0;
        end else if (run) begin
            acc_d.frac = frac_sum[FRAC_W-1:0];
            acc_d.ns   = acc_q.ns + NS_W'(step_int) + NS_W'(frac_sum[FRAC_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign time_q = acc_q.ns;

    // R3: time holds while counting is disabled
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(time_q));

    // R4: a zero step freezes the time
    a_r4_zero_step_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0 && !load) |=> $stable(time_q));

    // R5, R6: a load lands exactly and clears the fraction
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (time_q == $past(load_val) && acc_q.frac == '0));

    // R2: each step advances by the integer part plus at most one carry
    a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=>
        ((time_q == $past(time_q) + NS_W'($past(step_int))) ||
         (time_q == $past(time_q) + NS_W'($past(step_int)) + NS_W'(1))));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int FRAC_W = 32,
    localparam int NS_W  = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [4:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NS_W-1:0]   tod_ns
);

    logic            time_load;
    logic [NS_W-1:0] time_load_val;
    logic [NS_W-1:0] step_q;
    logic            run_q;

    tod_regif #(.BUS_W(BUS_W)) u_regif (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .live_time     (tod_ns),
        .time_load     (time_load),
        .time_load_val (time_load_val),
        .step_q        (step_q),
        .run_q         (run_q)
    );

    tod_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(NS_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .step     (step_q),
        .load     (time_load),
        .load_val (time_load_val),
        .time_q   (tod_ns)
    );

endmodule

// File: tb/tod_counter_test.sv
`timescale 1ns/1ps
module tod_counter_test;

    localparam logic [4:0] A_TLO = 5'h00;
    localparam logic [4:0] A_THI = 5'h04;
    localparam logic [4:0] A_SLO = 5'h08;
    localparam logic [4:0] A_SHI = 5'h0C;
    localparam logic [4:0] A_CTL = 5'h10;

    localparam int NV = 9;
    localparam logic [63:0] V_START [NV] = '{
        64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
        64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_FFFF_FFFE, 64'h0};
    localparam logic [63:0] V_STEP [NV] = '{
        64'h1_0000_0000, 64'h1_9999_9999, 64'h3_3333_3333, 64'h20_0000_0000,
        64'h0_8000_0000, 64'h0_0000_0001, 64'h1_0000_0000, 64'h20_0000_0000,
        64'h1_9999_9999};
    localparam int V_N [NV] = '{10, 10, 5, 4, 7, 3, 20, 2, 5};
    localparam logic [63:0] V_EXP [NV] = '{
        64'd10, 64'd15, 64'd15, 64'd128, 64'd3, 64'd0,
        64'd4, 64'h1_0000_003E, 64'd7};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] tod_ns;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tod_counter uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tod_ns(tod_ns));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd(A_TLO, lo);
        rd(A_THI, hi);
        t = {hi, lo};
    endtask

    task automatic set_time(input logic [63:0] t);
        wr(A_TLO, t[31:0]);
        wr(A_THI, t[63:32]);
    endtask

    task automatic set_step(input logic [63:0] s);
        wr(A_SLO, s[31:0]);
        wr(A_SHI, s[63:32]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [63:0] t, a, b;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 tod after reset", tod_ns, 64'h0);
        rd(A_SLO, w); chk("R1 step lo after reset", {32'h0, w}, 64'h0);
        rd(A_SHI, w); chk("R1 step hi after reset", {32'h0, w}, 64'h0);
        rd(A_CTL, w); chk("R1 ctrl after reset", {32'h0, w}, 64'h0);
        repeat (3) @(posedge clk); #1;
        chk("R1 no count after reset", tod_ns, 64'h0);

        // R2 vector table: start, step, N ticks, expected time
        for (int i = 0; i < NV; i++) begin
            wr(A_CTL, 32'h0);
            set_step(V_STEP[i]);
            set_time(V_START[i]);
            wr(A_CTL, 32'h1);
            repeat (V_N[i] - 1) @(posedge clk);
            #1;
            wr(A_CTL, 32'h0);
            chk($sformatf("R2 vector %0d tod", i), tod_ns, V_EXP[i]);
            rd_time(t);
            chk($sformatf("R2 vector %0d bus read", i), t, V_EXP[i]);
        end

        // R3 stopped clock holds
        a = tod_ns;
        repeat (10) @(posedge clk); #1;
        chk("R3 hold while disabled", tod_ns, a);
        rd(A_CTL, w); chk("R3 ctrl reads disabled", {32'h0, w}, 64'h0);

        // R5 low write staged only, high write commits
        wr(A_TLO, 32'h0000_1234);
        chk("R5 low write no effect", tod_ns, a);
        wr(A_THI, 32'h0000_0005);
        chk("R5 high write commits", tod_ns, 64'h5_0000_1234);

        // R4 zero step freezes even when enabled
        set_step(64'h0);
        wr(A_CTL, 32'h1);
        repeat (10) @(posedge clk); #1;
        chk("R4 zero step freezes", tod_ns, 64'h5_0000_1234);
        wr(A_CTL, 32'h0);

        // R6 load while running wins and clears fraction
        set_step(64'h1_9999_9999);
        wr(A_CTL, 32'h1);
        repeat (3) @(posedge clk); #1;
        set_time(64'h100);
        chk("R6 load wins over step", tod_ns, 64'h100);
        @(posedge clk); #1;
        chk("R6 first tick after load", tod_ns, 64'h101);
        @(posedge clk); #1;
        chk("R6 carry after cleared fraction", tod_ns, 64'h103);

        // R7 step low write staged only
        wr(A_CTL, 32'h0);
        set_step(64'h1_0000_0000);
        set_time(64'h0);
        wr(A_CTL, 32'h1);
        wr(A_SLO, 32'h8000_0000);
        a = tod_ns;
        @(posedge clk); #1;
        chk("R7 staged low keeps old step", tod_ns - a, 64'd1);
        rd(A_SLO, w); chk("R7 running step lo unchanged", {32'h0, w}, 64'h0);
        wr(A_CTL, 32'h0);
        wr(A_SHI, 32'h1);
        rd(A_SLO, w); chk("R7 step committed lo", {32'h0, w}, 64'h8000_0000);
        a = tod_ns;
        wr(A_CTL, 32'h1);
        @(posedge clk); #1;
        wr(A_CTL, 32'h0);
        chk("R7 new step applied", tod_ns - a, 64'd3);

        // R8 snapshot on low read
        set_time(64'h5_FFFF_FFF0);
        rd(A_TLO, w); chk("R8 low read", {32'h0, w}, 64'hFFFF_FFF0);
        set_time(64'h9_0000_0000);
        rd(A_THI, w); chk("R8 high read returns snapshot", {32'h0, w}, 64'h5);
        rd(A_THI, w); chk("R8 snapshot persists", {32'h0, w}, 64'h5);

        // R9 step and control readback
        set_step(64'hABCD_0123_4567_89EF);
        rd(A_SLO, w); chk("R9 step lo", {32'h0, w}, 64'h4567_89EF);
        rd(A_SHI, w); chk("R9 step hi", {32'h0, w}, 64'hABCD_0123);
        wr(A_CTL, 32'hFFFF_FFFE);
        rd(A_CTL, w); chk("R9 ctrl only bit 0", {32'h0, w}, 64'h0);
        chk("R9 ctrl bit1 does not enable", tod_ns, 64'h9_0000_0000);

        // R10 unmapped writes ignored, reads zero
        wr(A_CTL, 32'h0);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(A_CTL, w); chk("R10 ctrl untouched", {32'h0, w}, 64'h0);
        rd(A_SLO, w); chk("R10 step lo untouched", {32'h0, w}, 64'h4567_89EF);
        chk("R10 time untouched", tod_ns, 64'h9_0000_0000);
        rd(5'h14, w); chk("R10 unmapped read zero", {32'h0, w}, 64'h0);
        rd(5'h02, w); chk("R10 misaligned read zero", {32'h0, w}, 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule